// File: doc/BRIEF.md
# Seeded-state unpadded SHA-256 image checksum verifier

This block checks the integrity of a configuration image that arrives as a stream of bytes. The image opens with a 32-byte reference digest. Whole 64-byte payload blocks follow it. The block keeps the reference bytes and leaves them out of the hash. It feeds each payload block through the SHA-256 compression function, one round per clock. When the stream ends, it compares the resulting chaining state with the reference.

Two things set the hash apart from textbook SHA-256. The chaining state starts from a fixed, non-standard 256-bit seed, set by a parameter. No padding bit and no length block are ever appended. The digest is therefore the plain iterated compression of the raw payload blocks. A stream whose payload does not end on a 64-byte boundary is rejected with an error strobe.

A `start` pulse reseeds the state and opens a new image at any time. Bytes move on a valid/ready handshake, and the producer flags the final byte with `in_last`. Completion is signalled by a one-cycle `done`, which carries `match` or `len_err` alongside it.

Top module: `imgsum_check`

## Requirements
- R1: During reset, and in the cycle after `start`, `digest` equals the seed parameter. By default the seed is 4b6e434d 696e6572 20706c61 6365686f 6c646572 20534841 32353620 696e6974, with word 0 in bits 255:224.
- R2: The first 32 image bytes are stored as the reference digest and are not hashed. Changing only those bytes leaves the final `digest` unchanged.
- R3: Payload bytes form big-endian 32-bit words, with the first byte of each group of four in bits 31:24. Each 64-byte block goes through the standard 64-round SHA-256 schedule and constants.
- R4: After each block, the working variables are added modulo 2^32 to the chaining state. Images of one, two and three blocks chain correctly.
- R5: No padding or length block is added. With the standard seed, a hand-padded "abc" block yields the standard digest ba7816bf...f20015ad.
- R6: `len_err` pulses together with `done`, with `match` low, in the cycle after the accepting edge, in two cases. The first is when `in_last` comes inside the reference field. The second is when it comes on a payload byte that is not the 64th of its block.
- R7: When the last block completes, `match` is high with `done` exactly when the reference equals `digest`. A corrupted payload or reference byte gives a mismatch.
- R8: `match` and `len_err` are low whenever `done` is low, and `done` lasts one cycle.
- R9: `in_ready` is high from the cycle after `start` until a block's 64th byte. It stays low for 64 round cycles plus one update cycle. `done` therefore rises 65 cycles after the accepting edge of the final byte.
- R10: When idle, offered bytes are refused (`in_ready` low). A `start` in the middle of an image discards it and begins afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Reseed the state and open a new image |
| in_valid | input | 1 | Byte offered |
| in_byte | input | BYTE_W | Image data unit |
| in_last | input | 1 | Offered unit is the last of the image |
| in_ready | output | 1 | Block accepts a unit this cycle |
| digest | output | 256 | Chaining state, word 0 in bits 255:224 |
| done | output | 1 | One-cycle completion strobe |
| match | output | 1 | Reference equals digest (valid with done) |
| len_err | output | 1 | Image length not a whole number of blocks |

## Verification
The bench builds two copies with an 8-bit unit width. The first keeps the default seed. The second is given the standard SHA-256 seed, which lets the textbook "abc" digest serve as an absolute reference that does not depend on the bench's own model. Sweeps of one, two and three payload blocks, with every early-termination position class, cover the chaining, the length-error rule and the exact cycle counts. Corruption of a single reference byte or payload byte separates the exclusion of the header from the comparison itself.

// File: rtl/imgsum_pkg.sv
package imgsum_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned STATE_WORDS = 8;
   localparam int unsigned STATE_W     = WORD_W * STATE_WORDS;
   localparam int unsigned WIN_WORDS   = 16;
   localparam int unsigned BLOCK_W     = WORD_W * WIN_WORDS;
   localparam int unsigned ROUNDS      = 64;
   localparam int unsigned CNT_W       = $clog2(ROUNDS);

   typedef logic [WORD_W-1:0] word_t;
   typedef enum logic [2:0] {PH_IDLE, PH_HDR, PH_LOAD, PH_ROUND, PH_FOLD} phase_t;

   localparam logic [STATE_W-1:0] SEED_CUSTOM = {
      32'h4b6e434d, 32'h696e6572, 32'h20706c61, 32'h6365686f,
      32'h6c646572, 32'h20534841, 32'h32353620, 32'h696e6974};

   localparam logic [0:ROUNDS-1][WORD_W-1:0] KTAB = {
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

   function automatic word_t rotr(word_t x, int unsigned n);
      return (x >> n) | (x << (WORD_W - n));
   endfunction

   function automatic word_t big_sig0(word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t big_sig1(word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   function automatic word_t sml_sig0(word_t x);
      return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
   endfunction

   function automatic word_t sml_sig1(word_t x);
      return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
   endfunction
endpackage

// File: rtl/imgsum_sched.sv
module imgsum_sched
   import imgsum_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [BYTE_W-1:0] load_unit,
   input  logic              step_en,
   output word_t             w_cur
);
   logic [BLOCK_W-1:0] win_q;
   word_t              wv [WIN_WORDS];
   word_t              w_new;

   for (genvar i = 0; i < WIN_WORDS; i++) begin : g_unpack
      assign wv[i] = win_q[BLOCK_W-1-WORD_W*i -: WORD_W];
   end

   assign w_cur = wv[0];
   assign w_new = sml_sig1(wv[14]) + wv[9] + sml_sig0(wv[1]) + wv[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (load_en) begin
         win_q <= {win_q[BLOCK_W-BYTE_W-1:0], load_unit};
      end else if (step_en) begin
         win_q <= {win_q[BLOCK_W-WORD_W-1:0], w_new};
      end
   end
endmodule

// File: rtl/imgsum_round.sv
module imgsum_round
   import imgsum_pkg::*;
(
   input  logic [STATE_W-1:0] vars_i,
   input  word_t              k_i,
   input  word_t              w_i,
   output logic [STATE_W-1:0] vars_o
);
   word_t a, b, c, d, e, f, g, h, t1, t2;

   always_comb begin
      {a, b, c, d, e, f, g, h} = vars_i;
      t1     = h + big_sig1(e) + ((e & f) ^ (~e & g)) + k_i + w_i;
      t2     = big_sig0(a) + ((a & b) ^ (a & c) ^ (b & c));
      vars_o = {t1 + t2, a, b, c, d + t1, e, f, g};
   end
endmodule

// File: rtl/imgsum_check.sv
module imgsum_check
   import imgsum_pkg::*;
#(
   parameter logic [255:0] INIT_STATE = SEED_CUSTOM,
   parameter int unsigned  BYTE_W     = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_last,
   output logic              in_ready,
   output logic [255:0]      digest,
   output logic              done,
   output logic              match,
   output logic              len_err
);
   localparam int unsigned HDR_UNITS = STATE_W / BYTE_W;
   localparam int unsigned BLK_UNITS = BLOCK_W / BYTE_W;
   localparam logic [CNT_W-1:0] HDR_END = CNT_W'(HDR_UNITS - 1);
   localparam logic [CNT_W-1:0] BLK_END = CNT_W'(BLK_UNITS - 1);
   localparam logic [CNT_W-1:0] RND_END = CNT_W'(ROUNDS - 1);

   if (BYTE_W == 0 || BYTE_W > WORD_W || (WORD_W % BYTE_W) != 0) begin : g_bad_unit
      $error("imgsum_check: BYTE_W must divide the word width");
   end
   if (BLK_UNITS > ROUNDS) begin : g_bad_count
      $error("imgsum_check: unit counter too narrow for BYTE_W");
   end

   phase_t               ph_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [STATE_W-1:0]   h_q, v_q, ref_q, v_next, h_sum;
   logic                 fin_q, done_q, err_q, match_q;
   logic                 accept;
   word_t                w_cur;

   assign in_ready = (ph_q == PH_HDR) || (ph_q == PH_LOAD);
   assign accept   = in_valid && in_ready;

   imgsum_sched #(.BYTE_W(BYTE_W)) u_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (accept && (ph_q == PH_LOAD) && !start),
      .load_unit (in_byte),
      .step_en   (ph_q == PH_ROUND),
      .w_cur     (w_cur)
   );

   imgsum_round u_round (
      .vars_i (v_q),
      .k_i    (KTAB[cnt_q]),
      .w_i    (w_cur),
      .vars_o (v_next)
   );

   for (genvar i = 0; i < STATE_WORDS; i++) begin : g_fold
      assign h_sum[STATE_W-1-WORD_W*i -: WORD_W] =
         h_q[STATE_W-1-WORD_W*i -: WORD_W] + v_q[STATE_W-1-WORD_W*i -: WORD_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         cnt_q   <= '0;
         h_q     <= INIT_STATE;
         v_q     <= '0;
         ref_q   <= '0;
         fin_q   <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         match_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            ph_q    <= PH_HDR;
            cnt_q   <= '0;
            h_q     <= INIT_STATE;
            ref_q   <= '0;
            fin_q   <= 1'b0;
            err_q   <= 1'b0;
            match_q <= 1'b0;
         end else begin
            unique case (ph_q)
               PH_HDR: if (accept) begin
                  ref_q <= {ref_q[STATE_W-BYTE_W-1:0], in_byte};
                  cnt_q <= cnt_q + CNT_W'(1);
                  if (in_last) begin
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                     ph_q   <= PH_IDLE;
                  end else if (cnt_q == HDR_END) begin
                     cnt_q <= '0;
                     ph_q  <= PH_LOAD;
                  end
               end
               PH_LOAD: if (accept) begin
                  cnt_q <= cnt_q + CNT_W'(1);
                  if (cnt_q == BLK_END) begin
                     cnt_q <= '0;
                     v_q   <= h_q;
                     fin_q <= in_last;
                     ph_q  <= PH_ROUND;
                  end else if (in_last) begin
                     err_q  <= 1'b1;
                     done_q <= 1'b1;
                     ph_q   <= PH_IDLE;
                  end
               end
               PH_ROUND: begin
                  v_q   <= v_next;
                  cnt_q <= cnt_q + CNT_W'(1);
                  if (cnt_q == RND_END) ph_q <= PH_FOLD;
               end
               PH_FOLD: begin
                  h_q   <= h_sum;
                  cnt_q <= '0;
                  if (fin_q) begin
                     done_q  <= 1'b1;
                     match_q <= (h_sum == ref_q);
                     ph_q    <= PH_IDLE;
                  end else begin
                     ph_q <= PH_LOAD;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign digest  = h_q;
   assign done    = done_q;
   assign match   = done_q && match_q && !err_q;
   assign len_err = done_q && err_q;
endmodule

// File: rtl/imgsum_check_sva.sv
module imgsum_check_sva #(
   parameter logic [255:0] INIT_STATE = '0
)(
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         in_ready,
   input logic [255:0] digest,
   input logic         done,
   input logic         match,
   input logic         len_err
);
   // R1
   seed_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (digest == INIT_STATE));

   // R2
   hold_while_feeding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !start) |=> $stable(digest));

   // R6
   err_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> (done && !match));

   // R8
   match_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> done);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   ready_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> in_ready);
endmodule

bind imgsum_check imgsum_check_sva #(.INIT_STATE(INIT_STATE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .in_ready (in_ready),
   .digest   (digest),
   .done     (done),
   .match    (match),
   .len_err  (len_err)
);

// File: tb/imgsum_check_bench.sv
`timescale 1ns/1ps
module imgsum_check_bench;
   localparam logic [255:0] SEED_A = {
      32'h4b6e434d, 32'h696e6572, 32'h20706c61, 32'h6365686f,
      32'h6c646572, 32'h20534841, 32'h32353620, 32'h696e6974};
   localparam logic [255:0] SEED_STD = {
      32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
      32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
   localparam logic [255:0] ABC_SUM = {
      32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
      32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
   localparam int MAXB = 32 + 64*3;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
   logic [7:0] in_byte = '0;
   logic in_ready, done, match, len_err;
   logic [255:0] digest;
   logic s_ready, s_done, s_match, s_err;
   logic [255:0] s_digest;

   int checks = 0, fails = 0;
   logic [31:0] kt [64];
   logic [7:0]  img [MAXB];
   int          done_n;
   logic [255:0] got_dig, got_sdig;
   logic        got_match, got_err, got_smatch;

   always #2.5 clk = ~clk;

   imgsum_check u_imgsum_check (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
      .in_last(in_last), .in_ready(in_ready), .digest(digest), .done(done),
      .match(match), .len_err(len_err));

   imgsum_check #(.INIT_STATE(SEED_STD)) u_imgsum_check_std (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
      .in_last(in_last), .in_ready(s_ready), .digest(s_digest), .done(s_done),
      .match(s_match), .len_err(s_err));

   function automatic logic [31:0] rr(logic [31:0] x, int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic logic [255:0] compress(logic [255:0] hin, logic [511:0] blk);
      logic [31:0] w [64];
      logic [31:0] a, b, c, d, e, f, g, h, t1, t2;
      for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
      for (int i = 16; i < 64; i++)
         w[i] = (rr(w[i-2],17) ^ rr(w[i-2],19) ^ (w[i-2] >> 10)) + w[i-7]
              + (rr(w[i-15],7) ^ rr(w[i-15],18) ^ (w[i-15] >> 3)) + w[i-16];
      {a, b, c, d, e, f, g, h} = hin;
      for (int i = 0; i < 64; i++) begin
         t1 = h + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + kt[i] + w[i];
         t2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
         h = g; g = f; f = e; e = d + t1; d = c; c = b; b = a; a = t1 + t2;
      end
      return {hin[255:224]+a, hin[223:192]+b, hin[191:160]+c, hin[159:128]+d,
              hin[127:96]+e, hin[95:64]+f, hin[63:32]+g, hin[31:0]+h};
   endfunction

   function automatic logic [255:0] model(logic [255:0] seed, int nblk);
      logic [255:0] st = seed;
      logic [511:0] blk;
      for (int k = 0; k < nblk; k++) begin
         for (int j = 0; j < 64; j++) blk[511-8*j -: 8] = img[32 + 64*k + j];
         st = compress(st, blk);
      end
      return st;
   endfunction

   task automatic chk(bit ok, string req, logic [255:0] act, logic [255:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic fill(int seedv, int nblk);
      for (int i = 0; i < 32 + 64*nblk; i++) img[i] = 8'((i * seedv + 3 * seedv + 11) & 255);
   endtask

   task automatic set_ref(logic [255:0] r);
      for (int j = 0; j < 32; j++) img[j] = r[255-8*j -: 8];
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic put(logic [7:0] b, logic l);
      in_valid = 1'b1; in_byte = b; in_last = l;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   // sends img[0..last_idx], last flag on last_idx, then waits for done
   task automatic run(int last_idx);
      pulse_start();
      for (int i = 0; i <= last_idx; i++) put(img[i], i == last_idx);
      done_n = 0;
      while (!done && done_n < 400) begin
         @(negedge clk); done_n++;
      end
      got_dig = digest; got_match = match; got_err = len_err;
      got_sdig = s_digest; got_smatch = s_match;
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [255:0] e2, e1, e3;
      begin : kfill
         int p = 1;
         for (int t = 0; t < 64; t++) begin
            bit prime;
            real r;
            do begin
               p++; prime = 1;
               for (int q = 2; q * q <= p; q++) if (p % q == 0) prime = 0;
            end while (!prime);
            r = real'(p) ** (1.0 / 3.0);
            kt[t] = 32'(longint'($floor((r - $floor(r)) * 4294967296.0)));
         end
      end

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(digest == SEED_A, "R1 reset digest", digest, SEED_A);
      chk({in_ready, done, match, len_err} == 4'b0, "R8 reset flags",
          256'({in_ready, done, match, len_err}), 256'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R10 idle refuses bytes
      in_valid = 1'b1; in_byte = 8'h5a; in_last = 1'b1;
      repeat (4) @(negedge clk);
      chk(!in_ready && !done, "R10 idle refuses", 256'({in_ready, done}), 256'(0));
      in_valid = 1'b0; in_last = 1'b0;

      // R1 seed after start
      @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
      chk(digest == SEED_A && in_ready, "R1 seed after start", digest, SEED_A);

      // R3 R7 R9 good two-block image with latency
      fill(37, 2);
      e2 = model(SEED_A, 2);
      set_ref(e2);
      run(32 + 128 - 1);
      chk(done_n == 65, "R9 done latency", 256'(done_n), 256'(65));
      chk(got_dig == e2, "R3 two-block digest", got_dig, e2);
      chk(got_match && !got_err, "R7 match on good image", 256'({got_match, got_err}), 256'(2'b10));
      chk(!match && !done, "R8 match only with done", 256'({match, done}), 256'(0));

      // R7 corrupted payload byte
      img[32 + 77] = img[32 + 77] ^ 8'h04;
      run(32 + 128 - 1);
      chk(got_dig == model(SEED_A, 2), "R7 corrupted digest", got_dig, model(SEED_A, 2));
      chk(!got_match, "R7 corrupted payload mismatch", 256'(got_match), 256'(0));
      img[32 + 77] = img[32 + 77] ^ 8'h04;

      // R2 corrupted reference: digest unchanged, mismatch
      img[5] = img[5] ^ 8'h80;
      run(32 + 128 - 1);
      chk(got_dig == e2, "R2 header not hashed", got_dig, e2);
      chk(!got_match, "R7 corrupted reference mismatch", 256'(got_match), 256'(0));

      // R4 one and three blocks
      fill(53, 1);
      e1 = model(SEED_A, 1);
      set_ref(e1);
      run(32 + 64 - 1);
      chk(got_dig == e1 && got_match, "R4 one-block chain", got_dig, e1);
      fill(91, 3);
      e3 = model(SEED_A, 3);
      set_ref(e3);
      run(32 + 192 - 1);
      chk(got_dig == e3 && got_match, "R4 three-block chain", got_dig, e3);

      // R6 length errors
      fill(17, 2);
      run(32 + 70);
      chk(done_n == 0 && got_err && !got_match, "R6 mid-block last",
          256'({done_n[7:0], got_err, got_match}), 256'({8'd0, 2'b10}));
      run(10);
      chk(done_n == 0 && got_err, "R6 last in header", 256'({got_err}), 256'(1));
      run(31);
      chk(done_n == 0 && got_err, "R6 no payload", 256'({got_err}), 256'(1));
      run(32 + 62);
      chk(done_n == 0 && got_err, "R6 last on byte 63 of 64", 256'({got_err}), 256'(1));

      // R10 abort then good image
      fill(29, 2);
      e2 = model(SEED_A, 2);
      set_ref(e2);
      pulse_start();
      for (int i = 0; i < 50; i++) put(8'hee, 1'b0);
      run(32 + 128 - 1);
      chk(got_dig == e2 && got_match, "R10 restart after abort", got_dig, e2);

      // R5 standard seed, hand-padded abc
      for (int i = 0; i < 96; i++) img[i] = 8'h00;
      set_ref(ABC_SUM);
      img[32] = 8'h61; img[33] = 8'h62; img[34] = 8'h63; img[35] = 8'h80;
      img[95] = 8'h18;
      run(95);
      chk(got_sdig == ABC_SUM, "R5 standard abc digest", got_sdig, ABC_SUM);
      chk(got_smatch, "R5 standard abc match", 256'(got_smatch), 256'(1));
      chk(got_dig == model(SEED_A, 1), "R3 custom seed same block", got_dig, model(SEED_A, 1));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule